// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. A frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line idles high, and frames may be separated by idle time of any length. The block has no baud generator of its own. A one-cycle sample strobe, `smp_tick`, arrives sixteen times per bit period; for example, a 1.8432 MHz strobe gives 115200 baud. The line first passes through a two-flop synchronizer, and every decision is made on a strobe cycle.

The control is a four-state machine.
- **IDLE**: waits for a falling edge seen between two strobes. That edge is called the *start edge*.
- **START**: confirms the start bit at mid-cell. A line that has returned high there is a *glitch abort*, and the machine goes back to IDLE. When the cell wraps, the *start confirm* transition moves the machine to DATA.
- **DATA**: takes three samples in the centre of each bit cell and decides the bit by majority. When the eighth cell wraps, the *last bit* transition moves the machine to STOP.
- **STOP**: votes the stop bit the same way and presents the byte with its flags. Three quarters of the way through the stop cell, the *rearm* transition returns the machine to IDLE. If a start edge is seen on that same strobe, the *fast restart* transition goes directly to START instead.

The early rearm lets the block keep up with a transmitter whose clock runs somewhat fast.

Top module: `serial_rx_os`

## Requirements
- R1: After reset, `rx_valid`, `rx_noise` and `rx_ferr` are 0 and `rx_data` is 0x00.
- R2: A start edge is a strobe that sees the synchronized line low when the previous strobe saw it high. Cell positions are counted from that strobe, which is position 0 of the start cell. A steady low line is never taken as a start edge.
- R3: If the line is high at start-cell position 8, the frame is abandoned and no byte is reported. A line that is still low at position 8 starts a frame.
- R4: Data bit k is decided by majority over the line values at positions 7, 8 and 9 of cell k+1, counted from the start edge. Bits are assembled least significant first into `rx_data`.
- R5: `rx_noise` is 1 for a frame if the three samples of any data bit or of the stop bit disagree. Line values at any other cell position have no effect on the byte or on the flags.
- R6: If the majority of the stop bit samples is low, `rx_ferr` is 1. The received byte is still reported.
- R7: `rx_valid` is high for exactly one clock, on the strobe at stop-cell position 9. `rx_data`, `rx_noise` and `rx_ferr` change only together with `rx_valid` and hold their values until the next report.
- R8: Start detection is rearmed at stop-cell position 12. A start edge seen at position 12 or later begins the next frame, so a stop bit only 12 strobes long loses no byte.
- R9: While the line is held low after a frame (a break), no further byte is reported. Any idle gap before a frame is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sample strobe, 16 per bit period |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock pulse when a byte is reported |
| rx_noise | output | 1 | Sample disagreement seen in the reported frame |
| rx_ferr | output | 1 | Stop bit was voted low in the reported frame |

## Verification
Two functions can fall on one strobe: the rearm at stop-cell position 12, and the detection of the next frame's falling edge. The bench provokes this by sending a frame whose stop bit lasts exactly 12 strobes, so the next start bit is first seen on the rearm strobe. It then sends a second frame with a 13-strobe stop bit. Both bytes must come out intact, with clean flags and the expected number of reports. Each case is judged at the ports, by how many reports appear and by their contents.

// File: rtl/serial_rx_os_pkg.sv
package serial_rx_os_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/rx_cell_counter.sv
module rx_cell_counter #(
    parameter int OS    = 16,
    parameter int REARM = 12,
    localparam int PH_W = $clog2(OS),
    localparam int MID  = OS / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clr,
    output logic [PH_W-1:0] ph,
    output logic            pos_early,
    output logic            pos_mid,
    output logic            pos_late,
    output logic            pos_rearm,
    output logic            pos_wrap
);

    logic [PH_W-1:0] ph_nx;

    assign ph_nx = ph + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ph <= '0;
        else if (clr)  ph <= '0;
        else if (tick) ph <= ph_nx;
    end

    assign pos_early = tick && (ph_nx == PH_W'(MID - 1));
    assign pos_mid   = tick && (ph_nx == PH_W'(MID));
    assign pos_late  = tick && (ph_nx == PH_W'(MID + 1));
    assign pos_rearm = tick && (ph_nx == PH_W'(REARM));
    assign pos_wrap  = tick && (ph_nx == '0);

    // R4
    ph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(ph));

endmodule

// File: rtl/rx_vote.sv
module rx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic take_a,
    input  logic take_b,
    output logic vote,
    output logic split
);

    logic samp_a;
    logic samp_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else begin
            if (take_a) samp_a <= line;
            if (take_b) samp_b <= line;
        end
    end

    always_comb begin
        vote  = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);
        split = !((samp_a == samp_b) && (samp_b == line));
    end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_os_pkg::*;
#(
    parameter int DW = 8,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          pos_mid,
    input  logic          pos_late,
    input  logic          pos_rearm,
    input  logic          pos_wrap,
    input  logic          vote,
    input  logic          split,
    output logic          clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_noise,
    output logic          rx_ferr
);

    rx_state_t      state;
    rx_state_t      nstate;
    logic           last_s;
    logic [IW-1:0]  bit_idx;
    logic [DW-1:0]  shreg;
    logic           noise_acc;
    logic           edge_seen;

    assign edge_seen = tick && !line && last_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next state and counter restart
    always_comb begin
        nstate = state;
        clr    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (edge_seen) begin
                    nstate = ST_START;
                    clr    = 1'b1;
                end
            end
            ST_START: begin
                if (pos_mid && line)  nstate = ST_IDLE;
                else if (pos_wrap)    nstate = ST_DATA;
            end
            ST_DATA: begin
                if (pos_wrap && (bit_idx == IW'(DW - 1))) nstate = ST_STOP;
            end
            ST_STOP: begin
                if (pos_rearm) begin
                    if (edge_seen) begin
                        nstate = ST_START;
                        clr    = 1'b1;
                    end else begin
                        nstate = ST_IDLE;
                    end
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_s    <= 1'b1;
            bit_idx   <= '0;
            shreg     <= '0;
            noise_acc <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            rx_noise  <= 1'b0;
            rx_ferr   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick) last_s <= line;
            if (clr) begin
                noise_acc <= 1'b0;
                bit_idx   <= '0;
            end
            unique case (state)
                ST_IDLE, ST_START: ;
                ST_DATA: begin
                    if (pos_late) begin
                        shreg     <= {vote, shreg[DW-1:1]};
                        noise_acc <= noise_acc | split;
                    end
                    if (pos_wrap) bit_idx <= bit_idx + 1'b1;
                end
                ST_STOP: begin
                    if (pos_late) begin
                        rx_valid <= 1'b1;
                        rx_data  <= shreg;
                        rx_noise <= noise_acc | split;
                        rx_ferr  <= !vote;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3
    glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && pos_mid && line) |=> (state == ST_IDLE));

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tick && !line && last_s) |=> (state == ST_START));

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && pos_rearm) |=> (state != ST_STOP));

    // R7
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
    parameter int DW     = 8,
    parameter int OS     = 16,
    parameter int STAGES = 2,
    localparam int REARM = (OS * 3) / 4,
    localparam int PH_W  = $clog2(OS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_tick,
    input  logic          rx_in,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_noise,
    output logic          rx_ferr
);

    logic            line_s;
    logic            clr;
    logic [PH_W-1:0] ph;
    logic            pos_early;
    logic            pos_mid;
    logic            pos_late;
    logic            pos_rearm;
    logic            pos_wrap;
    logic            vote;
    logic            split;

    rx_line_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_in),
        .d_sync  (line_s)
    );

    rx_cell_counter #(.OS(OS), .REARM(REARM)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (smp_tick),
        .clr       (clr),
        .ph        (ph),
        .pos_early (pos_early),
        .pos_mid   (pos_mid),
        .pos_late  (pos_late),
        .pos_rearm (pos_rearm),
        .pos_wrap  (pos_wrap)
    );

    rx_vote u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (line_s),
        .take_a (pos_early),
        .take_b (pos_mid),
        .vote   (vote),
        .split  (split)
    );

    rx_frame_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (smp_tick),
        .line      (line_s),
        .pos_mid   (pos_mid),
        .pos_late  (pos_late),
        .pos_rearm (pos_rearm),
        .pos_wrap  (pos_wrap),
        .vote      (vote),
        .split     (split),
        .clr       (clr),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_noise  (rx_noise),
        .rx_ferr   (rx_ferr)
    );

endmodule

// File: tb/sim_serial_rx_os.sv
`timescale 1ns/1ps
module sim_serial_rx_os;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_noise;
    logic       rx_ferr;

    int checks = 0;
    int errors = 0;
    int cap_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    logic [7:0] cap_data = 8'h00;
    logic [7:0] prev_data = 8'h00;
    logic       cap_noise = 1'b0;
    logic       cap_ferr = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_os u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_tick (smp_tick),
        .rx_in    (rx_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_noise (rx_noise),
        .rx_ferr  (rx_ferr)
    );

    // sample strobe: one clock in four
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            smp_tick = (div == 0);
        end
    end

    // output monitor, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                cap_cnt++;
                prev_data = cap_data;
                cap_data  = rx_data;
                cap_noise = rx_noise;
                cap_ferr  = rx_ferr;
                run_len++;
            end else begin
                run_len = 0;
            end
            if (run_len > max_run) max_run = run_len;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!smp_tick) @(posedge clk);
        #1;
    endtask

    task automatic put(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            rx_in = v;
            wait_tick();
        end
    endtask

    task automatic send(input logic [7:0] d, input int stop_len, input int nbit,
                        input logic [15:0] nmask, input logic stop_lv);
        put(1'b0, 16);
        for (int b = 0; b < 8; b++)
            for (int s = 0; s < 16; s++)
                put((b == nbit && nmask[s]) ? ~d[b] : d[b], 1);
        put(stop_lv, stop_len);
    endtask

    task automatic t_reset();
        chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        chk(rx_data == 8'h00, "R1 data", rx_data, 0);
        chk(rx_noise == 1'b0 && rx_ferr == 1'b0, "R1 flags", {rx_noise, rx_ferr}, 0);
    endtask

    task automatic t_clean(input logic [7:0] d);
        int c0 = cap_cnt;
        send(d, 16, -1, 16'h0000, 1'b1);
        put(1'b1, 10);
        chk(cap_cnt == c0 + 1, "R2 one report", cap_cnt - c0, 1);
        chk(cap_data == d, "R4 data", cap_data, d);
        chk(!cap_noise && !cap_ferr, "R5 clean flags", {cap_noise, cap_ferr}, 0);
    endtask

    task automatic t_noise();
        int c0 = cap_cnt;
        send(8'h5A, 16, 3, 16'h0080, 1'b1);
        put(1'b1, 10);
        chk(cap_cnt == c0 + 1 && cap_data == 8'h5A, "R4 majority keeps bit", cap_data, 8'h5A);
        chk(cap_noise == 1'b1, "R5 noise on one sample", cap_noise, 1);
        send(8'h5A, 16, 3, 16'h0180, 1'b1);
        put(1'b1, 10);
        chk(cap_data == 8'h52, "R4 majority flips bit", cap_data, 8'h52);
        chk(cap_noise == 1'b1, "R5 noise on two samples", cap_noise, 1);
        send(8'hC3, 16, 2, 16'hF83F, 1'b1);
        put(1'b1, 10);
        chk(cap_data == 8'hC3, "R5 off-centre ignored data", cap_data, 8'hC3);
        chk(cap_noise == 1'b0, "R5 off-centre ignored noise", cap_noise, 0);
    endtask

    task automatic t_ferr_break();
        int c0 = cap_cnt;
        send(8'h96, 16, -1, 16'h0000, 1'b0);
        chk(cap_cnt == c0 + 1 && cap_data == 8'h96, "R6 byte kept", cap_data, 8'h96);
        chk(cap_ferr == 1'b1, "R6 framing flag", cap_ferr, 1);
        put(1'b0, 200);
        chk(cap_cnt == c0 + 1, "R9 break gives no report", cap_cnt - c0, 1);
        put(1'b1, 20);
    endtask

    task automatic t_glitch();
        int c0 = cap_cnt;
        put(1'b0, 8);
        put(1'b1, 200);
        chk(cap_cnt == c0, "R3 glitch rejected", cap_cnt - c0, 0);
        put(1'b0, 9);
        put(1'b1, 7 + 128 + 16 + 10);
        chk(cap_cnt == c0 + 1, "R3 low at mid accepted", cap_cnt - c0, 1);
        chk(cap_data == 8'hFF && !cap_noise, "R3 accepted frame data", cap_data, 8'hFF);
    endtask

    task automatic t_fast_tx();
        int c0 = cap_cnt;
        send(8'h81, 12, -1, 16'h0000, 1'b1);
        send(8'h7E, 13, -1, 16'h0000, 1'b1);
        send(8'h24, 16, -1, 16'h0000, 1'b1);
        put(1'b1, 10);
        chk(cap_cnt == c0 + 3, "R8 no lost byte", cap_cnt - c0, 3);
        chk(prev_data == 8'h7E, "R8 second byte", prev_data, 8'h7E);
        chk(cap_data == 8'h24 && !cap_ferr && !cap_noise, "R8 third byte", cap_data, 8'h24);
    endtask

    task automatic t_pulse_hold();
        put(1'b1, 300);
        chk(rx_data == cap_data, "R7 data held", rx_data, cap_data);
        chk(max_run == 1, "R7 one-cycle valid", max_run, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        put(1'b1, 20);
        t_reset();
        t_clean(8'hA5);
        t_clean(8'h3C);
        t_clean(8'h00);
        t_clean(8'hFF);
        t_noise();
        t_ferr_break();
        t_glitch();
        t_fast_tx();
        t_pulse_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule